// File: doc/BRIEF.md
# MOESI Snooping Line-State Controller

This block keeps the coherence state of a small array of cache lines, one entry per set, under an invalidation protocol with five states: Modified, Owned, Exclusive, Shared and Invalid. The local processor sends three kinds of request: read, write and evict. Each request is looked up in the state array. It either completes locally, which is a hit, or it raises one bus request and waits for the bus to finish that transaction. The state reached depends on the command: after a read, on the shared line the bus sampled; after the other commands, on the command alone.

At the same time the block watches commands from other caches on the shared bus. For each snooped command it updates the addressed line. One cycle later it drives the shared line and a combined memory-inhibit/data-supply response. A line held dirty in the Owned state answers snooped reads in place of memory, so memory is not written until the line is evicted. When a snoop and a processor request arrive in the same cycle, the snoop is handled first. The tag store, data array, arbitration and memory are outside the block.

Top module: `moesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid (state code 0), `cpu_ready` is 1 and `cpu_resp_valid`, `snp_shared`, `snp_supply` and `bus_req_valid` are 0. State codes: I=0, S=1, E=2, O=3, M=4. Processor ops: read=0, write=1, evict=2. Bus commands: bus read=0, get permission=1, read-with-intent-to-modify=2, write-back=3.
- R2: A read to an Invalid line misses and requests a bus read. When the bus completes, the line becomes E if `bus_shared` was 0 at `bus_done`, and S if it was 1. A read to any valid line is a hit and changes nothing.
- R3: A write to an E line is a hit, raises no bus request and leaves the line in M.
- R4: A write to an S or O line misses, requests get permission, and leaves the line in M.
- R5: A write to an Invalid line misses, requests read-with-intent-to-modify, and leaves the line in M.
- R6: A snooped bus read to an M line asserts `snp_shared` and `snp_supply`, moves the line to O, and raises no write-back request.
- R7: Every snooped bus read to an O line asserts `snp_shared` and `snp_supply`, and the line stays O.
- R8: A snooped bus read to an E or S line asserts `snp_shared` only, and an E line becomes S. A snooped bus read to an I line gives no response.
- R9: A snooped get permission or read-with-intent-to-modify moves a valid line to I and leaves the other sets unchanged. `snp_supply` is asserted only for read-with-intent-to-modify to an M or O line.
- R10: Evicting an M or O line misses, requests a write-back, and leaves the line I. Evicting an E, S or I line is a hit with no bus request and leaves the line I.
- R11: When `snp_valid` and `cpu_valid` are both high in a cycle, only the snoop is taken and `cpu_ready` is 0. The processor request is accepted in a later cycle.
- R12: A snooped write-back gives no response and changes no state.
- R13: While a bus request is outstanding, `bus_req_valid`, `bus_req_cmd` and `bus_req_set` stay steady until `bus_done`, and `cpu_ready` stays 0 until the state is installed.
- R14: If a snoop arrives in the cycle in which a completed transaction would install its state, the snoop goes first and the install follows without loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_op | input | 2 | Request kind: 0 read, 1 write, 2 evict |
| cpu_set | input | IW | Set addressed by the processor |
| cpu_ready | output | 1 | Request accepted this cycle if valid |
| cpu_resp_valid | output | 1 | Lookup result valid (one cycle after accept) |
| cpu_resp_hit | output | 1 | Request completed without the bus |
| cpu_resp_state | output | 3 | Line state found at lookup |
| snp_valid | input | 1 | Snooped bus command present |
| snp_cmd | input | 2 | Snooped command code |
| snp_set | input | IW | Set addressed by the snoop |
| snp_shared | output | 1 | Shared-line response (one cycle after snoop) |
| snp_supply | output | 1 | Inhibit memory and supply data |
| bus_req_valid | output | 1 | Bus request outstanding |
| bus_req_cmd | output | 2 | Requested bus command |
| bus_req_set | output | IW | Set of the requested transaction |
| bus_done | input | 1 | Bus transaction finished (one-cycle pulse) |
| bus_shared | input | 1 | Shared line sampled at completion |

## Verification
The assertions assume that `bus_done` is pulsed only while a request is outstanding. They also assume that no snoop addresses the set of an outstanding transaction between its request and its install. Under these conditions the bus has ordered the local transaction before any conflicting one. The directed tasks follow both rules: the bench bus model pulses `bus_done` only after seeing `bus_req_valid`, and every snoop issued during a pending transaction targets a different set. One command of each kind is applied in each relevant state, and the states are read back through lookups.

// File: rtl/moesi_pkg.sv
package moesi_pkg;
  typedef enum logic [2:0] {
    ST_I = 3'd0,
    ST_S = 3'd1,
    ST_E = 3'd2,
    ST_O = 3'd3,
    ST_M = 3'd4
  } line_st_t;

  typedef enum logic [1:0] {
    CMD_BR    = 2'd0,
    CMD_GP    = 2'd1,
    CMD_RWITM = 2'd2,
    CMD_WB    = 2'd3
  } bus_cmd_t;

  typedef enum logic [1:0] {
    OP_RD  = 2'd0,
    OP_WR  = 2'd1,
    OP_EV  = 2'd2,
    OP_NOP = 2'd3
  } cpu_op_t;
endpackage

// File: rtl/moesi_state_array.sv
module moesi_state_array #(
  parameter int SETS = 16,
  parameter int IW   = 4,
  parameter int SW   = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [SW-1:0] wdata,
  input  logic [IW-1:0] ra_addr,
  output logic [SW-1:0] ra_data,
  input  logic [IW-1:0] rb_addr,
  output logic [SW-1:0] rb_data
);
  logic [SW-1:0] mem [SETS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SETS; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign ra_data = mem[ra_addr];
  assign rb_data = mem[rb_addr];
endmodule

// File: rtl/moesi_cpu_decode.sv
module moesi_cpu_decode
  import moesi_pkg::*;
(
  input  line_st_t cur,
  input  cpu_op_t  op,
  output logic     need_bus,
  output bus_cmd_t cmd,
  output logic     local_wr,
  output line_st_t local_nxt
);
  always_comb begin
    need_bus  = 1'b0;
    cmd       = CMD_BR;
    local_wr  = 1'b0;
    local_nxt = cur;
    unique case (op)
      OP_RD: begin
        if (cur == ST_I) begin
          need_bus = 1'b1;
          cmd      = CMD_BR;
        end
      end
      OP_WR: begin
        unique case (cur)
          ST_I: begin need_bus = 1'b1; cmd = CMD_RWITM; end
          ST_S, ST_O: begin need_bus = 1'b1; cmd = CMD_GP; end
          ST_E: begin local_wr = 1'b1; local_nxt = ST_M; end
          default: ;
        endcase
      end
      OP_EV: begin
        if (cur == ST_M || cur == ST_O) begin
          need_bus = 1'b1;
          cmd      = CMD_WB;
        end else begin
          local_wr  = 1'b1;
          local_nxt = ST_I;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/moesi_snoop_decode.sv
module moesi_snoop_decode
  import moesi_pkg::*;
(
  input  line_st_t cur,
  input  bus_cmd_t cmd,
  output line_st_t nxt,
  output logic     wr,
  output logic     shared,
  output logic     supply
);
  logic dirty;
  assign dirty = (cur == ST_M) || (cur == ST_O);

  always_comb begin
    nxt    = cur;
    shared = 1'b0;
    supply = 1'b0;
    unique case (cmd)
      CMD_BR: begin
        if (cur != ST_I) shared = 1'b1;
        supply = dirty;
        if (cur == ST_E) nxt = ST_S;
        if (cur == ST_M) nxt = ST_O;
      end
      CMD_GP: begin
        nxt = ST_I;
      end
      CMD_RWITM: begin
        nxt    = ST_I;
        supply = dirty;
      end
      default: ;
    endcase
    wr = (nxt != cur);
  end
endmodule

// File: rtl/moesi_line_ctrl.sv
module moesi_line_ctrl
  import moesi_pkg::*;
#(
  parameter int SETS = 16,
  localparam int IW = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpu_valid,
  input  logic [1:0]    cpu_op,
  input  logic [IW-1:0] cpu_set,
  output logic          cpu_ready,
  output logic          cpu_resp_valid,
  output logic          cpu_resp_hit,
  output logic [2:0]    cpu_resp_state,
  input  logic          snp_valid,
  input  logic [1:0]    snp_cmd,
  input  logic [IW-1:0] snp_set,
  output logic          snp_shared,
  output logic          snp_supply,
  output logic          bus_req_valid,
  output logic [1:0]    bus_req_cmd,
  output logic [IW-1:0] bus_req_set,
  input  logic          bus_done,
  input  logic          bus_shared
);
  localparam int SW = 3;

  typedef enum logic [1:0] {C_IDLE, C_WAIT, C_FIN} ctl_t;

  ctl_t          ctl;
  bus_cmd_t      pend_cmd;
  logic [IW-1:0] pend_set;
  logic          pend_shd;

  logic [SW-1:0] cpu_cur_raw, snp_cur_raw;
  line_st_t      cpu_cur, snp_cur;

  logic     cd_need_bus, cd_local_wr;
  bus_cmd_t cd_cmd;
  line_st_t cd_nxt;

  logic     sd_wr, sd_shared, sd_supply;
  line_st_t sd_nxt;

  logic          cpu_go, fin_wr;
  line_st_t      fin_state;
  logic          we;
  logic [IW-1:0] waddr;
  logic [SW-1:0] wdata;

  assign cpu_cur = line_st_t'(cpu_cur_raw);
  assign snp_cur = line_st_t'(snp_cur_raw);

  moesi_state_array #(.SETS(SETS), .IW(IW), .SW(SW)) u_states (
    .clk     (clk),
    .rst     (rst),
    .we      (we),
    .waddr   (waddr),
    .wdata   (wdata),
    .ra_addr (cpu_set),
    .ra_data (cpu_cur_raw),
    .rb_addr (snp_set),
    .rb_data (snp_cur_raw)
  );

  moesi_cpu_decode u_cpu_dec (
    .cur       (cpu_cur),
    .op        (cpu_op_t'(cpu_op)),
    .need_bus  (cd_need_bus),
    .cmd       (cd_cmd),
    .local_wr  (cd_local_wr),
    .local_nxt (cd_nxt)
  );

  moesi_snoop_decode u_snp_dec (
    .cur    (snp_cur),
    .cmd    (bus_cmd_t'(snp_cmd)),
    .nxt    (sd_nxt),
    .wr     (sd_wr),
    .shared (sd_shared),
    .supply (sd_supply)
  );

  // snoop wins the single decision slot each cycle
  assign cpu_ready = (ctl == C_IDLE) && !snp_valid;
  assign cpu_go    = cpu_valid && cpu_ready;
  assign fin_wr    = (ctl == C_FIN) && !snp_valid;

  always_comb begin
    unique case (pend_cmd)
      CMD_BR:  fin_state = pend_shd ? ST_S : ST_E;
      CMD_WB:  fin_state = ST_I;
      default: fin_state = ST_M;
    endcase
  end

  // one write port: snoop, then bus install, then local update
  always_comb begin
    we    = 1'b0;
    waddr = cpu_set;
    wdata = cd_nxt;
    if (snp_valid && sd_wr) begin
      we = 1'b1; waddr = snp_set; wdata = sd_nxt;
    end else if (fin_wr) begin
      we = 1'b1; waddr = pend_set; wdata = fin_state;
    end else if (cpu_go && cd_local_wr) begin
      we = 1'b1; waddr = cpu_set; wdata = cd_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl            <= C_IDLE;
      pend_cmd       <= CMD_BR;
      pend_set       <= '0;
      pend_shd       <= 1'b0;
      cpu_resp_valid <= 1'b0;
      cpu_resp_hit   <= 1'b0;
      cpu_resp_state <= '0;
      snp_shared     <= 1'b0;
      snp_supply     <= 1'b0;
      bus_req_valid  <= 1'b0;
      bus_req_cmd    <= '0;
      bus_req_set    <= '0;
    end else begin
      cpu_resp_valid <= cpu_go;
      if (cpu_go) begin
        cpu_resp_hit   <= !cd_need_bus;
        cpu_resp_state <= cpu_cur;
      end
      snp_shared <= snp_valid && sd_shared;
      snp_supply <= snp_valid && sd_supply;
      unique case (ctl)
        C_IDLE: begin
          if (cpu_go && cd_need_bus) begin
            bus_req_valid <= 1'b1;
            bus_req_cmd   <= cd_cmd;
            bus_req_set   <= cpu_set;
            pend_cmd      <= cd_cmd;
            pend_set      <= cpu_set;
            ctl           <= C_WAIT;
          end
        end
        C_WAIT: begin
          if (bus_done) begin
            bus_req_valid <= 1'b0;
            pend_shd      <= bus_shared;
            ctl           <= C_FIN;
          end
        end
        default: begin
          if (!snp_valid) ctl <= C_IDLE;
        end
      endcase
    end
  end

  assert_snoop_first_R11: assert property (@(posedge clk) disable iff (rst)
    (snp_valid && cpu_valid) |=> !cpu_resp_valid);

  assert_req_hold_R13: assert property (@(posedge clk) disable iff (rst)
    (bus_req_valid && !bus_done) |=>
      (bus_req_valid && $stable(bus_req_cmd) && $stable(bus_req_set)));

  assert_miss_goes_to_bus_R2: assert property (@(posedge clk) disable iff (rst)
    (cpu_resp_valid && !cpu_resp_hit) |-> bus_req_valid);

  assert_hit_no_bus_R3: assert property (@(posedge clk) disable iff (rst)
    (cpu_resp_valid && cpu_resp_hit) |-> !bus_req_valid);

  assert_supply_from_read_R6: assert property (@(posedge clk) disable iff (rst)
    snp_supply |-> ($past(snp_valid) &&
                    ($past(snp_cmd) == 2'd0 || $past(snp_cmd) == 2'd2)));

  assert_wb_silent_R12: assert property (@(posedge clk) disable iff (rst)
    (snp_shared || snp_supply) |-> ($past(snp_cmd) != 2'd3));

  assert_shared_only_on_read_R8: assert property (@(posedge clk) disable iff (rst)
    snp_shared |-> ($past(snp_cmd) == 2'd0));
endmodule

// File: tb/moesi_line_ctrl_tb.sv
`timescale 1ns/1ps
module moesi_line_ctrl_tb;
  localparam int SETS = 16;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cpu_valid = 1'b0;
  logic [1:0]    cpu_op = '0;
  logic [IW-1:0] cpu_set = '0;
  logic          cpu_ready, cpu_resp_valid, cpu_resp_hit;
  logic [2:0]    cpu_resp_state;
  logic          snp_valid = 1'b0;
  logic [1:0]    snp_cmd = '0;
  logic [IW-1:0] snp_set = '0;
  logic          snp_shared, snp_supply;
  logic          bus_req_valid;
  logic [1:0]    bus_req_cmd;
  logic [IW-1:0] bus_req_set;
  logic          bus_done = 1'b0;
  logic          bus_shared = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  moesi_line_ctrl #(.SETS(SETS)) u_dut (
    .clk(clk), .rst(rst),
    .cpu_valid(cpu_valid), .cpu_op(cpu_op), .cpu_set(cpu_set),
    .cpu_ready(cpu_ready), .cpu_resp_valid(cpu_resp_valid),
    .cpu_resp_hit(cpu_resp_hit), .cpu_resp_state(cpu_resp_state),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_set(snp_set),
    .snp_shared(snp_shared), .snp_supply(snp_supply),
    .bus_req_valid(bus_req_valid), .bus_req_cmd(bus_req_cmd),
    .bus_req_set(bus_req_set), .bus_done(bus_done), .bus_shared(bus_shared)
  );

  localparam logic [1:0] RD = 2'd0, WR = 2'd1, EV = 2'd2;
  localparam logic [1:0] BR = 2'd0, GP = 2'd1, RW = 2'd2, WB = 2'd3;
  localparam int SI = 0, SS = 1, SE = 2, SO = 3, SM = 4;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 20 && !cpu_ready; i++) @(negedge clk);
  endtask

  // bus model: answers an outstanding request after two cycles
  task automatic serve_bus(input logic shd);
    logic [1:0] c0;
    logic [IW-1:0] s0;
    c0 = bus_req_cmd; s0 = bus_req_set;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk("R13 req held", int'(bus_req_valid), 1);
      chk("R13 cmd stable", int'(bus_req_cmd), int'(c0));
      chk("R13 set stable", int'(bus_req_set), int'(s0));
      chk("R13 not ready", int'(cpu_ready), 0);
    end
    bus_done = 1'b1; bus_shared = shd;
    @(negedge clk);
    bus_done = 1'b0; bus_shared = 1'b0;
    wait_ready();
  endtask

  task automatic cpu_acc(input logic [1:0] op, input int set, input logic shd,
                         output int hit, output int st, output int cmd);
    wait_ready();
    cpu_valid = 1'b1; cpu_op = op; cpu_set = IW'(set);
    @(negedge clk);
    cpu_valid = 1'b0;
    hit = int'(cpu_resp_hit);
    st  = int'(cpu_resp_state);
    cmd = -1;
    if (!cpu_resp_hit) begin
      cmd = int'(bus_req_cmd);
      chk("R13 req set", int'(bus_req_set), set);
      serve_bus(shd);
    end
  endtask

  function automatic int lookup_state_dummy(input int x);
    return x;
  endfunction

  // a read to a valid line reports its state without changing it
  task automatic peek(input int set, output int st);
    int h, c;
    cpu_acc(RD, set, 1'b0, h, st, c);
  endtask

  task automatic snoop(input logic [1:0] cmd, input int set,
                       output int sh, output int sup);
    snp_valid = 1'b1; snp_cmd = cmd; snp_set = IW'(set);
    @(negedge clk);
    snp_valid = 1'b0;
    sh = int'(snp_shared); sup = int'(snp_supply);
  endtask

  task automatic t_reset();
    int h, st, c;
    chk("R1 ready", int'(cpu_ready), 1);
    chk("R1 resp_valid", int'(cpu_resp_valid), 0);
    chk("R1 shared", int'(snp_shared), 0);
    chk("R1 supply", int'(snp_supply), 0);
    chk("R1 bus_req", int'(bus_req_valid), 0);
    cpu_acc(EV, 3, 1'b0, h, st, c);
    chk("R1 state I", st, SI);
    cpu_acc(EV, 15, 1'b0, h, st, c);
    chk("R1 state I top set", st, SI);
  endtask

  task automatic t_read_miss();
    int h, st, c;
    cpu_acc(RD, 1, 1'b0, h, st, c);
    chk("R2 read miss", h, 0);
    chk("R2 bus read", c, int'(BR));
    peek(1, st);
    chk("R2 exclusive", st, SE);
    cpu_acc(RD, 2, 1'b1, h, st, c);
    chk("R2 bus read shared", c, int'(BR));
    cpu_acc(RD, 2, 1'b0, h, st, c);
    chk("R2 read hit", h, 1);
    chk("R2 shared", st, SS);
  endtask

  task automatic t_write_excl();
    int h, st, c;
    cpu_acc(WR, 1, 1'b0, h, st, c);
    chk("R3 write hit", h, 1);
    chk("R3 saw E", st, SE);
    peek(1, st);
    chk("R3 now M", st, SM);
  endtask

  task automatic t_snoop_owner();
    int sh, sup, st;
    snoop(BR, 1, sh, sup);
    chk("R6 shared", sh, 1);
    chk("R6 supply", sup, 1);
    chk("R6 no writeback", int'(bus_req_valid), 0);
    peek(1, st);
    chk("R6 now O", st, SO);
    for (int k = 0; k < 2; k++) begin
      snoop(BR, 1, sh, sup);
      chk("R7 shared", sh, 1);
      chk("R7 supply", sup, 1);
    end
    peek(1, st);
    chk("R7 stays O", st, SO);
  endtask

  task automatic t_upgrade();
    int h, st, c;
    cpu_acc(WR, 1, 1'b0, h, st, c);
    chk("R4 O write miss", h, 0);
    chk("R4 get permission", c, int'(GP));
    peek(1, st);
    chk("R4 O to M", st, SM);
    cpu_acc(WR, 2, 1'b0, h, st, c);
    chk("R4 S get permission", c, int'(GP));
    peek(2, st);
    chk("R4 S to M", st, SM);
  endtask

  task automatic t_write_miss();
    int h, st, c;
    cpu_acc(WR, 5, 1'b0, h, st, c);
    chk("R5 miss", h, 0);
    chk("R5 rwitm", c, int'(RW));
    peek(5, st);
    chk("R5 M", st, SM);
  endtask

  task automatic t_snoop_clean();
    int h, st, c, sh, sup;
    cpu_acc(RD, 6, 1'b0, h, st, c);
    snoop(BR, 6, sh, sup);
    chk("R8 E shared", sh, 1);
    chk("R8 E no supply", sup, 0);
    peek(6, st);
    chk("R8 E to S", st, SS);
    snoop(BR, 6, sh, sup);
    chk("R8 S shared", sh, 1);
    chk("R8 S no supply", sup, 0);
    snoop(BR, 7, sh, sup);
    chk("R8 I silent shared", sh, 0);
    chk("R8 I silent supply", sup, 0);
  endtask

  task automatic t_invalidate();
    int h, st, c, sh, sup;
    snoop(RW, 5, sh, sup);
    chk("R9 rwitm M supply", sup, 1);
    chk("R9 rwitm no shared", sh, 0);
    cpu_acc(EV, 5, 1'b0, h, st, c);
    chk("R9 M to I", st, SI);
    snoop(GP, 6, sh, sup);
    chk("R9 gp no supply", sup, 0);
    cpu_acc(EV, 6, 1'b0, h, st, c);
    chk("R9 S to I", st, SI);
    peek(1, st);
    chk("R9 other set kept", st, SM);
    cpu_acc(RD, 9, 1'b0, h, st, c);
    snoop(RW, 9, sh, sup);
    chk("R9 rwitm E no supply", sup, 0);
    cpu_acc(EV, 9, 1'b0, h, st, c);
    chk("R9 E to I", st, SI);
  endtask

  task automatic t_evict();
    int h, st, c, sh, sup;
    cpu_acc(EV, 1, 1'b0, h, st, c);
    chk("R10 M evict miss", h, 0);
    chk("R10 M writeback", c, int'(WB));
    cpu_acc(EV, 1, 1'b0, h, st, c);
    chk("R10 M evicted to I", st, SI);
    cpu_acc(WR, 8, 1'b0, h, st, c);
    snoop(BR, 8, sh, sup);
    cpu_acc(EV, 8, 1'b0, h, st, c);
    chk("R10 O writeback", c, int'(WB));
    chk("R10 O seen", st, SO);
    cpu_acc(RD, 10, 1'b0, h, st, c);
    cpu_acc(EV, 10, 1'b0, h, st, c);
    chk("R10 E evict hit", h, 1);
    chk("R10 E seen", st, SE);
    cpu_acc(EV, 10, 1'b0, h, st, c);
    chk("R10 E to I", st, SI);
  endtask

  task automatic t_collide();
    int h, st, c;
    wait_ready();
    cpu_valid = 1'b1; cpu_op = RD; cpu_set = 4'd11;
    snp_valid = 1'b1; snp_cmd = BR; snp_set = 4'd12;
    #0.1;
    chk("R11 not ready on snoop", int'(cpu_ready), 0);
    @(negedge clk);
    snp_valid = 1'b0;
    chk("R11 cpu held off", int'(cpu_resp_valid), 0);
    @(negedge clk);
    cpu_valid = 1'b0;
    chk("R11 accepted later", int'(cpu_resp_valid), 1);
    chk("R11 miss", int'(cpu_resp_hit), 0);
    serve_bus(1'b0);
    peek(11, st);
    chk("R11 installed E", st, SE);
    h = 0; c = 0;
  endtask

  task automatic t_wb_snoop();
    int h, st, c, sh, sup;
    cpu_acc(WR, 13, 1'b0, h, st, c);
    snoop(WB, 13, sh, sup);
    chk("R12 no shared", sh, 0);
    chk("R12 no supply", sup, 0);
    peek(13, st);
    chk("R12 state kept", st, SM);
  endtask

  task automatic t_install_defer();
    int h, st, c, sh, sup;
    wait_ready();
    cpu_valid = 1'b1; cpu_op = RD; cpu_set = 4'd14;
    @(negedge clk);
    cpu_valid = 1'b0;
    @(negedge clk);
    bus_done = 1'b1; bus_shared = 1'b1;
    @(negedge clk);
    bus_done = 1'b0; bus_shared = 1'b0;
    snoop(BR, 13, sh, sup);
    chk("R14 snoop served first", sup, 1);
    wait_ready();
    peek(14, st);
    chk("R14 install kept", st, SS);
    peek(13, st);
    chk("R14 snooped line O", st, SO);
    h = 0; c = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_read_miss();
    t_write_excl();
    t_snoop_owner();
    t_upgrade();
    t_write_miss();
    t_snoop_clean();
    t_invalidate();
    t_evict();
    t_collide();
    t_wb_snoop();
    t_install_defer();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule